// File: doc/BRIEF.md
# Precision-Time Event Timestamp Capture Unit

This block watches a received byte stream and a transmit start strobe and copies a free-running 64-bit time value into one of two stamp registers: one for receive and one for transmit. On the receive side a classifier follows each frame byte by byte. It checks the Ethernet type, an optional IPv4/UDP header with the event port, and the precision-time message header. If the frame qualifies and receive stamping is enabled, the unit stores the time of the frame's first byte when the frame ends and pulses a status flag beside that frame. On the transmit side a marked frame start captures the time at once.

Each stamp register is a two-state slot, FREE or HELD. A capture is possible only in FREE. A read of the upper word moves the slot back to FREE. So at most one receive stamp and one transmit stamp are outstanding, and each belongs to exactly one frame. Software reads a stamp through a 32-bit word port that is chosen by a 2-bit address.

The receive classifier has the states IDLE, ETH (link header), IP (IPv4 header), UDP (UDP header), PTP (message header), HIT (qualified, wait for end) and SKIP (rejected, wait for end). A start byte always enters ETH. From ETH, the type byte at index 13 leads to PTP (type 0x88F7 with layer-2 allowed), to IP (type 0x0800 with layer-4 allowed) or to SKIP. IP leads to UDP on its last header byte, or to SKIP on a bad version, length or protocol. UDP leads to PTP after byte 7, or to SKIP on a port mismatch. PTP leads to HIT or SKIP on its decisive byte. An end byte returns the classifier to IDLE from any state.

Top module: `ptp_cap_unit`

## Requirements
- R1: After reset both stamp-valid outputs are 0, the receive status flag is 0 and the read word is 0 at every read address.
- R2: An Ethernet type of 0x88F7 in bytes 12–13 qualifies on the layer-2 path only in filter modes 2'b01 (version 2, layer 2) and 2'b11 (version 2, both paths). The PTP header then starts at byte 14.
- R3: An IPv4 frame qualifies on the layer-4 path in modes 2'b00, 2'b10 and 2'b11. Such a frame has type 0x0800, version nibble 4, header length IHL ≥ 5 in the low nibble of byte 14, protocol 17 in byte 23, and UDP source and destination ports both equal to the event port. The PTP header starts at byte 14 + 4·IHL + 8.
- R4: In the version-2 modes a frame is stamped when the low nibble of PTP byte 0 (message type) is 0 to 3, which includes the path-delay types 2 and 3, and the low nibble of PTP byte 1 (version) is 2.
- R5: In mode 2'b00 (version 1, layer 4 only) the event port is rx_match[23:8], and PTP byte 32 must equal rx_match[7:0]. Layer-2 frames never qualify in this mode. In the version-2 modes the event port is fixed at 319.
- R6: A frame that ends before its decisive byte (PTP byte 1 in version-2 modes, PTP byte 32 in version-1 mode) is not stamped.
- R7: For a qualifying frame the receive stamp takes the value time_now had in the cycle of the frame's start byte. The stamp is committed on the second clock edge after the end byte, together with a one-cycle rx_ts_flag pulse. This happens only if rx_en is 1 at that edge.
- R8: While a stamp is valid, no new capture occurs on that side. The stamp value does not change and rx_ts_flag stays 0.
- R9: rd_data is rd_addr-selected: 0 gives receive bits 31:0, 1 gives receive bits 63:32, 2 gives transmit bits 31:0 and 3 gives transmit bits 63:32. With rd_en set, address 1 or 3 clears the matching valid on the next edge, while address 0 or 2 leaves it set.
- R10: A cycle with tx_sof, tx_mark and tx_en all 1 and no valid transmit stamp captures time_now of that cycle, and tx_stamp_vld is 1 after the edge. Without the mark or the enable nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Live time value |
| rx_en | input | 1 | Receive stamping enable |
| rx_mode | input | 2 | Receive filter mode |
| rx_match | input | 24 | Version-1 port [23:8] and message type [7:0] |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Receive byte |
| tx_en | input | 1 | Transmit stamping enable |
| tx_sof | input | 1 | Transmit frame start |
| tx_mark | input | 1 | Frame requests a stamp |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Selected stamp word |
| rx_ts_flag | output | 1 | Frame just stamped |
| rx_stamp_vld | output | 1 | Receive stamp held |
| tx_stamp_vld | output | 1 | Transmit stamp held |

## Verification
A classifier stuck in the wrong state shows at the ports as a missing or extra rx_ts_flag pulse exactly two cycles after the end byte of a frame. A slot left in FREE while it should be HELD lets the next qualifying frame overwrite the stamp, so rd_data changes within one frame time. A slot left in HELD keeps its valid set after an upper-word read, which is visible one cycle later. Random frames, with corrupted fields and lengths cut near the decisive byte, are compared against a bench parser, and the directed cases cover the lock and the read ordering.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ETH, ST_IP, ST_UDP, ST_PTP, ST_HIT, ST_SKIP
    } cls_state_t;

    typedef enum logic [1:0] {
        FLT_V1_L4  = 2'b00,
        FLT_V2_L2  = 2'b01,
        FLT_V2_L4  = 2'b10,
        FLT_V2_ANY = 2'b11
    } flt_mode_t;

    typedef enum logic [1:0] {
        RD_RX_LO = 2'd0, RD_RX_HI = 2'd1, RD_TX_LO = 2'd2, RD_TX_HI = 2'd3
    } rd_sel_t;

    typedef enum logic {SLOT_FREE, SLOT_HELD} slot_state_t;

    localparam logic [15:0] ETYPE_PTP    = 16'h88F7;
    localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
    localparam logic [15:0] PTP_EVT_PORT = 16'd319;
    localparam logic [7:0]  IP_PROTO_UDP = 8'd17;
endpackage

// File: rtl/ptp_rx_classifier.sv
module ptp_rx_classifier
    import ptp_cap_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int V1_CTRL_OFS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  flt_mode_t   mode,
    input  logic [23:0] match,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_data,
    output logic        frame_done,
    output logic        frame_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] IDX_TYPE_H = CNT_W'(12);
    localparam logic [CNT_W-1:0] IDX_TYPE_L = CNT_W'(13);
    localparam logic [CNT_W-1:0] L2_BASE    = CNT_W'(14);
    localparam logic [CNT_W-1:0] IDX_PROTO  = CNT_W'(23);
    localparam logic [CNT_W-1:0] UDP_LEN    = CNT_W'(8);
    localparam logic [CNT_W-1:0] V1_OFS     = CNT_W'(V1_CTRL_OFS);

    cls_state_t       state_q, state_d, cur, walk;
    logic [CNT_W-1:0] cnt_q, cnt_d, idx;
    logic [CNT_W-1:0] ipend_q, ipend_d, base_q, base_d;
    logic [CNT_W-1:0] rel_udp, rel_ptp;
    logic [7:0]       hold_q, hold_d;
    logic             done_d, hit_d;
    logic             l2_ok, l4_ok, is_v1;
    logic [15:0]      want_port;

    assign is_v1     = (mode == FLT_V1_L4);
    assign l2_ok     = (mode == FLT_V2_L2) || (mode == FLT_V2_ANY);
    assign l4_ok     = (mode != FLT_V2_L2);
    assign want_port = is_v1 ? match[23:8] : PTP_EVT_PORT;

    // next-state and field tracking
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hold_d  = hold_q;
        ipend_d = ipend_q;
        base_d  = base_q;
        done_d  = 1'b0;
        hit_d   = 1'b0;
        idx     = in_sof ? '0 : cnt_q;
        cur     = in_sof ? ST_ETH : state_q;
        walk    = cur;
        rel_udp = idx - ipend_q;
        rel_ptp = idx - base_q;
        if (in_valid) begin
            unique case (cur)
                ST_ETH: begin
                    if (idx == IDX_TYPE_H) begin
                        hold_d = in_data;
                    end else if (idx == IDX_TYPE_L) begin
                        if ({hold_q, in_data} == ETYPE_PTP) begin
                            walk   = l2_ok ? ST_PTP : ST_SKIP;
                            base_d = L2_BASE;
                        end else if ({hold_q, in_data} == ETYPE_IPV4) begin
                            walk = l4_ok ? ST_IP : ST_SKIP;
                        end else begin
                            walk = ST_SKIP;
                        end
                    end
                end
                ST_IP: begin
                    if (idx == L2_BASE) begin
                        if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5)
                            walk = ST_SKIP;
                        ipend_d = L2_BASE + CNT_W'({in_data[3:0], 2'b00});
                    end else if (idx == IDX_PROTO) begin
                        if (in_data != IP_PROTO_UDP)
                            walk = ST_SKIP;
                    end else if (idx == ipend_q - CNT_W'(1)) begin
                        walk = ST_UDP;
                    end
                end
                ST_UDP: begin
                    unique case (rel_udp[2:0])
                        3'd0, 3'd2: hold_d = in_data;
                        3'd1, 3'd3: begin
                            if ({hold_q, in_data} != want_port)
                                walk = ST_SKIP;
                        end
                        3'd7: begin
                            walk   = ST_PTP;
                            base_d = ipend_q + UDP_LEN;
                        end
                        default: ;
                    endcase
                end
                ST_PTP: begin
                    if (is_v1) begin
                        if (rel_ptp == V1_OFS)
                            walk = (in_data == match[7:0]) ? ST_HIT : ST_SKIP;
                    end else if (rel_ptp == '0) begin
                        if (in_data[3:0] > 4'd3)
                            walk = ST_SKIP;
                    end else if (rel_ptp == CNT_W'(1)) begin
                        walk = (in_data[3:0] == 4'd2) ? ST_HIT : ST_SKIP;
                    end
                end
                ST_IDLE, ST_HIT, ST_SKIP: ;
                default: walk = ST_SKIP;
            endcase
            cnt_d = (idx == CNT_MAX) ? idx : idx + CNT_W'(1);
            if (in_eof) begin
                done_d  = 1'b1;
                hit_d   = (walk == ST_HIT);
                state_d = ST_IDLE;
            end else begin
                state_d = walk;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            hold_q     <= '0;
            ipend_q    <= '0;
            base_q     <= '0;
            frame_done <= 1'b0;
            frame_hit  <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            hold_q     <= hold_d;
            ipend_q    <= ipend_d;
            base_q     <= base_d;
            frame_done <= done_d;
            frame_hit  <= hit_d;
        end
    end
endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot
    import ptp_cap_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_req,
    input  logic [TW-1:0] cap_time,
    input  logic          rel_req,
    output logic [TW-1:0] stamp,
    output logic          held,
    output logic          took
);
    slot_state_t st_q, st_d;
    logic        grab;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE: if (cap_req) st_d = SLOT_HELD;
            SLOT_HELD: if (rel_req) st_d = SLOT_FREE;
            default:   st_d = SLOT_FREE;
        endcase
    end

    assign grab = (st_q == SLOT_FREE) && cap_req;
    assign held = (st_q == SLOT_HELD);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
            took  <= 1'b0;
        end else begin
            took <= grab;
            if (grab) stamp <= cap_time;
        end
    end
endmodule

// File: rtl/ptp_cap_unit.sv
module ptp_cap_unit
    import ptp_cap_pkg::*;
#(
    parameter int TW          = 64,
    parameter int CNT_W       = 8,
    parameter int V1_CTRL_OFS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_now,
    input  logic          rx_en,
    input  logic [1:0]    rx_mode,
    input  logic [23:0]   rx_match,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic [7:0]    rx_data,
    input  logic          tx_en,
    input  logic          tx_sof,
    input  logic          tx_mark,
    input  logic          rd_en,
    input  logic [1:0]    rd_addr,
    output logic [TW/2-1:0] rd_data,
    output logic          rx_ts_flag,
    output logic          rx_stamp_vld,
    output logic          tx_stamp_vld
);
    localparam int HALF  = TW / 2;
    localparam int LANES = 2;
    localparam int RX    = 0;
    localparam int TX    = 1;

    logic [TW-1:0]    sof_time_q;
    logic             cls_done, cls_hit;
    logic [LANES-1:0] cap_req, rel_req, held, took;
    logic [TW-1:0]    cap_time   [LANES];
    logic [TW-1:0]    slot_stamp [LANES];
    rd_sel_t          sel;

    assign sel = rd_sel_t'(rd_addr);

    always_ff @(posedge clk) begin
        if (!rst_n)                  sof_time_q <= '0;
        else if (rx_valid && rx_sof) sof_time_q <= time_now;
    end

    ptp_rx_classifier #(.CNT_W(CNT_W), .V1_CTRL_OFS(V1_CTRL_OFS)) u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (flt_mode_t'(rx_mode)),
        .match      (rx_match),
        .in_valid   (rx_valid),
        .in_sof     (rx_sof),
        .in_eof     (rx_eof),
        .in_data    (rx_data),
        .frame_done (cls_done),
        .frame_hit  (cls_hit)
    );

    assign cap_req[RX]  = cls_done && cls_hit && rx_en;
    assign cap_time[RX] = sof_time_q;
    assign rel_req[RX]  = rd_en && (sel == RD_RX_HI);
    assign cap_req[TX]  = tx_sof && tx_mark && tx_en;
    assign cap_time[TX] = time_now;
    assign rel_req[TX]  = rd_en && (sel == RD_TX_HI);

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        ptp_stamp_slot #(.TW(TW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_req  (cap_req[g]),
            .cap_time (cap_time[g]),
            .rel_req  (rel_req[g]),
            .stamp    (slot_stamp[g]),
            .held     (held[g]),
            .took     (took[g])
        );
    end

    assign rx_ts_flag   = took[RX];
    assign rx_stamp_vld = held[RX];
    assign tx_stamp_vld = held[TX];

    always_comb begin
        unique case (sel)
            RD_RX_LO: rd_data = slot_stamp[RX][HALF-1:0];
            RD_RX_HI: rd_data = slot_stamp[RX][TW-1:HALF];
            RD_TX_LO: rd_data = slot_stamp[TX][HALF-1:0];
            RD_TX_HI: rd_data = slot_stamp[TX][TW-1:HALF];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptp_cap_checker.sv
module ptp_cap_checker #(
    parameter int TW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] time_now,
    input logic          rx_en,
    input logic          tx_en,
    input logic          tx_sof,
    input logic          tx_mark,
    input logic          rd_en,
    input logic [1:0]    rd_addr,
    input logic          rx_ts_flag,
    input logic          rx_stamp_vld,
    input logic          tx_stamp_vld,
    input logic [TW-1:0] rx_stamp,
    input logic [TW-1:0] tx_stamp
);
    logic rx_hi_rd, tx_hi_rd, tx_go;
    assign rx_hi_rd = rd_en && (rd_addr == 2'd1);
    assign tx_hi_rd = rd_en && (rd_addr == 2'd3);
    assign tx_go    = tx_sof && tx_mark && tx_en;

    assert_rx_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stamp_vld && !rx_hi_rd) |=> (rx_stamp_vld && $stable(rx_stamp)));
    assert_tx_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stamp_vld && !tx_hi_rd) |=> (tx_stamp_vld && $stable(tx_stamp)));
    assert_no_flag_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stamp_vld && !rx_hi_rd) |=> !rx_ts_flag);
    assert_rx_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hi_rd |=> !rx_stamp_vld);
    assert_tx_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hi_rd |=> !tx_stamp_vld);
    assert_flag_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_stamp_vld) |-> rx_ts_flag);
    assert_flag_has_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ts_flag |-> rx_stamp_vld);
    assert_rx_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_stamp_vld) |=> !rx_stamp_vld);
    assert_tx_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && !tx_stamp_vld) |=> (tx_stamp_vld && tx_stamp == $past(time_now)));
    assert_tx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_go && !tx_stamp_vld) |=> !tx_stamp_vld);
endmodule

bind ptp_cap_unit ptp_cap_checker #(.TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .time_now     (time_now),
    .rx_en        (rx_en),
    .tx_en        (tx_en),
    .tx_sof       (tx_sof),
    .tx_mark      (tx_mark),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rx_ts_flag   (rx_ts_flag),
    .rx_stamp_vld (rx_stamp_vld),
    .tx_stamp_vld (tx_stamp_vld),
    .rx_stamp     (slot_stamp[0]),
    .tx_stamp     (slot_stamp[1])
);

// File: tb/ptp_cap_unit_test.sv
module ptp_cap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = 64'h0000_0003_FFFF_FF00;
    logic        rx_en = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [1:0]  rx_mode = 2'b11;
    logic [23:0] rx_match = 24'h0;
    logic [7:0]  rx_data = 8'h0;
    logic        tx_en = 1'b0, tx_sof = 1'b0, tx_mark = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        rx_ts_flag, rx_stamp_vld, tx_stamp_vld;

    int nchk = 0, nbad = 0;
    logic [7:0]  fb [0:127];
    int          flen;
    bit          exp_rx_vld = 0, exp_tx_vld = 0;
    logic [63:0] exp_rx = '0, exp_tx = '0;

    always #10 clk = ~clk;
    always @(posedge clk) time_now <= time_now + 64'd13;

    ptp_cap_unit uut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .rx_en(rx_en),
        .rx_mode(rx_mode), .rx_match(rx_match), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .tx_en(tx_en),
        .tx_sof(tx_sof), .tx_mark(tx_mark), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rx_ts_flag(rx_ts_flag),
        .rx_stamp_vld(rx_stamp_vld), .tx_stamp_vld(tx_stamp_vld)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    // frame builders
    task automatic mk_l2(input logic [3:0] mt, input logic [3:0] ver, input int len);
        for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
        fb[12] = 8'h88; fb[13] = 8'hF7;
        fb[14] = {4'h1, mt}; fb[15] = {4'h0, ver};
        flen = len;
    endtask

    task automatic mk_l4(input logic [3:0] ihl, input logic [7:0] proto,
                         input logic [15:0] sp, input logic [15:0] dp,
                         input logic [3:0] mt, input logic [3:0] ver,
                         input logic [7:0] v1msg, input int extra);
        int u;
        for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
        fb[12] = 8'h08; fb[13] = 8'h00;
        fb[14] = {4'h4, ihl}; fb[23] = proto;
        u = 14 + 4 * int'(ihl);
        fb[u] = sp[15:8]; fb[u+1] = sp[7:0]; fb[u+2] = dp[15:8]; fb[u+3] = dp[7:0];
        fb[u+8] = {4'h0, mt}; fb[u+9] = {4'h0, ver}; fb[u+40] = v1msg;
        flen = u + 41 + extra;
    endtask

    // independent parse of the frame buffer
    function automatic bit ref_hit(input logic [1:0] md, input logic [23:0] mr);
        bit l2 = (md == 2'b01) || (md == 2'b11);
        bit l4 = (md != 2'b01);
        int base, u;
        logic [15:0] port = (md == 2'b00) ? mr[23:8] : 16'd319;
        if (flen < 14) return 0;
        if ({fb[12], fb[13]} == 16'h88F7) begin
            if (!l2) return 0;
            base = 14;
        end else if ({fb[12], fb[13]} == 16'h0800) begin
            if (!l4 || flen < 15) return 0;
            if (fb[14][7:4] != 4'd4 || fb[14][3:0] < 4'd5) return 0;
            if (flen < 24 || fb[23] != 8'd17) return 0;
            u = 14 + 4 * int'(fb[14][3:0]);
            if (flen < u + 4) return 0;
            if ({fb[u], fb[u+1]} != port || {fb[u+2], fb[u+3]} != port) return 0;
            base = u + 8;
        end else return 0;
        if (md == 2'b00) begin
            if (flen <= base + 32) return 0;
            return fb[base+32] == mr[7:0];
        end
        if (flen <= base + 1) return 0;
        return (fb[base][3:0] <= 4'd3) && (fb[base+1][3:0] == 4'd2);
    endfunction

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic run_rx(input string req);
        logic [63:0] t_sof = '0;
        logic [31:0] lo, hi;
        bit h = ref_hit(rx_mode, rx_match);
        bit cap;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == flen - 1); rx_data = fb[i];
            if (i == 0) t_sof = time_now;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        cap = h && rx_en && !exp_rx_vld;
        chk({req, " flag"}, 64'(rx_ts_flag), 64'(cap));
        if (cap) begin exp_rx_vld = 1; exp_rx = t_sof; end
        chk({req, " vld"}, 64'(rx_stamp_vld), 64'(exp_rx_vld));
        peek(2'd0, lo); peek(2'd1, hi);
        chk({req, " stamp"}, {hi, lo}, exp_rx);
    endtask

    task automatic read_word(input logic [1:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        if (a == 2'd1) exp_rx_vld = 0;
        if (a == 2'd3) exp_tx_vld = 0;
    endtask

    task automatic run_tx(input bit m, input string req);
        logic [63:0] t;
        logic [31:0] lo, hi;
        bit cap;
        @(negedge clk);
        tx_sof = 1'b1; tx_mark = m; t = time_now;
        @(negedge clk);
        tx_sof = 1'b0; tx_mark = 1'b0;
        cap = m && tx_en && !exp_tx_vld;
        if (cap) begin exp_tx_vld = 1; exp_tx = t; end
        chk({req, " tx vld"}, 64'(tx_stamp_vld), 64'(exp_tx_vld));
        peek(2'd2, lo); peek(2'd3, hi);
        chk({req, " tx stamp"}, {hi, lo}, exp_tx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx vld", 64'(rx_stamp_vld), 0);
        chk("R1 tx vld", 64'(tx_stamp_vld), 0);
        chk("R1 flag", 64'(rx_ts_flag), 0);
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), w);
            chk("R1 rd_data", 64'(w), 0);
        end
        rx_en = 1'b1; tx_en = 1'b1;

        // R2 layer-2 path per mode
        rx_mode = 2'b10; mk_l2(4'd0, 4'd2, 40); run_rx("R2 l2 in l4-only");
        rx_mode = 2'b01; mk_l2(4'd0, 4'd2, 40); run_rx("R2 l2 sync");
        // R8 locked: second frame ignored, low read keeps lock (R9)
        mk_l2(4'd1, 4'd2, 44); run_rx("R8 locked frame");
        read_word(2'd0);
        chk("R9 lo read keeps vld", 64'(rx_stamp_vld), 1);
        read_word(2'd1);
        chk("R9 hi read clears vld", 64'(rx_stamp_vld), 0);
        // R4 message types
        rx_mode = 2'b11;
        mk_l2(4'd3, 4'd2, 50); run_rx("R4 pdelay resp"); read_word(2'd1);
        mk_l2(4'd8, 4'd2, 50); run_rx("R4 general msg");
        mk_l2(4'd0, 4'd1, 50); run_rx("R4 wrong version");
        // R6 short frames
        mk_l2(4'd0, 4'd2, 15); run_rx("R6 one short");
        mk_l2(4'd2, 4'd2, 16); run_rx("R6 exact length"); read_word(2'd1);
        // R3 layer-4 path
        rx_mode = 2'b10;
        mk_l4(4'd5, 8'd17, 16'd319, 16'd319, 4'd1, 4'd2, 8'h00, 0); run_rx("R3 ihl5"); read_word(2'd1);
        mk_l4(4'd7, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'h00, -30); run_rx("R3 ihl7"); read_word(2'd1);
        mk_l4(4'd5, 8'd17, 16'd320, 16'd319, 4'd0, 4'd2, 8'h00, 0); run_rx("R3 src port");
        mk_l4(4'd5, 8'd6, 16'd319, 16'd319, 4'd0, 4'd2, 8'h00, 0); run_rx("R3 tcp");
        // R5 version-1 mode
        rx_mode = 2'b00; rx_match = {16'd319, 8'h01};
        mk_l4(4'd6, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'h01, 0); run_rx("R5 v1 match"); read_word(2'd1);
        mk_l4(4'd6, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'h00, 0); run_rx("R5 v1 mismatch");
        mk_l4(4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'h01, -1); run_rx("R6 v1 short");
        mk_l2(4'd0, 4'd2, 60); run_rx("R5 l2 in v1");
        rx_match = {16'd320, 8'h00};
        mk_l4(4'd5, 8'd17, 16'd320, 16'd320, 4'd0, 4'd1, 8'h00, 2); run_rx("R5 v1 port"); read_word(2'd1);
        // R7 enable gate
        rx_en = 1'b0; rx_mode = 2'b11;
        mk_l2(4'd0, 4'd2, 30); run_rx("R7 disabled");
        rx_en = 1'b1;
        // R10 transmit
        run_tx(1'b0, "R10 no mark");
        tx_en = 1'b0; run_tx(1'b1, "R10 disabled"); tx_en = 1'b1;
        run_tx(1'b1, "R10 capture");
        run_tx(1'b1, "R8 tx locked");
        read_word(2'd2);
        chk("R9 tx lo keeps", 64'(tx_stamp_vld), 1);
        read_word(2'd3);
        chk("R9 tx hi clears", 64'(tx_stamp_vld), 0);
        run_tx(1'b1, "R10 recapture");

        // random mix
        for (int n = 0; n < 80; n++) begin
            int kind = int'($urandom % 3);
            rx_mode  = 2'($urandom);
            rx_match = {($urandom % 5 == 0) ? 16'd320 : 16'd319, 8'($urandom % 2)};
            rx_en    = ($urandom % 8) != 0;
            if (kind == 0)
                mk_l2(4'($urandom % 5), ($urandom % 4 == 0) ? 4'd1 : 4'd2,
                      14 + int'($urandom % 8));
            else if (kind == 1)
                mk_l4(4'(5 + $urandom % 3), ($urandom % 6 == 0) ? 8'd6 : 8'd17,
                      ($urandom % 6 == 0) ? 16'd320 : 16'd319, 16'd319,
                      4'($urandom % 5), 4'd2, 8'($urandom % 2),
                      int'($urandom % 40) - 34);
            else begin
                mk_l2(4'd0, 4'd2, 30); fb[13] = 8'h06;
            end
            run_rx("R7 random");
            if ($urandom % 2 == 0) read_word(2'd1);
            if ($urandom % 4 == 0) run_tx($urandom % 2 == 0, "R10 random");
            if ($urandom % 4 == 0) read_word(2'd3);
        end
        report();
    end
endmodule